// File: doc/BRIEF.md
# Eight-Pin GPIO Controller with Interrupts

This block is an eight-pin general-purpose I/O peripheral sitting on a simple byte-wide register bus with an address, a write strobe, write data and combinational read data. Each pin can be made an input or an output. The data port is reached through a window of addresses in which the word-address bits themselves act as a per-pin mask, so one write can update any subset of outputs without a read-modify-write, and one read returns only the selected pins.

Every pin also feeds an interrupt detector. The detector can be set per pin to level or edge sensing, to one edge or both, and to high/rising or low/falling polarity. Latched edge events are held until software clears them through a write-one-to-clear register. Raw and enable-gated status can both be read, and a single interrupt line is the OR of the gated status. Pin inputs are resynchronised by two flops before use. A per-pin mode byte is stored for an external pad multiplexer and driven out unchanged.

Top module: `gpio8_ctrl`

## Requirements
- R1: After reset every configuration register, the output latch and all latched edge events are 0, so `pin_oe`, `pin_out`, `pad_mode` and `irq_out` are 0 and every register reads 0.
- R2: A write with `bus_addr[10]`=0 and `bus_addr[1:0]`=0 treats `bus_addr[9:2]` as a pin mask: output-latch bits whose mask bit is 1 take the write data, the others keep their value; `pin_out` shows the latch.
- R3: A read in the data window returns, for each pin whose mask bit is 1, the output latch for an output pin or the synchronised input for an input pin, and 0 for unmasked pins; an input change is visible two clock edges after it is applied.
- R4: The direction byte at 0x400 reads back what was written; bit 1 makes the pin an output, and `pin_oe` equals this byte.
- R5: With the sense bit (0x404) at 1, the pin's raw status follows the synchronised input: high level when the event bit (0x40C) is 1, low level when it is 0.
- R6: With sense 0 and the both-edges bit (0x408) at 0, a rising edge latches the raw bit when the event bit is 1 and a falling edge when it is 0; a latched bit stays set until cleared.
- R7: With sense 0 and both-edges 1, either edge latches the raw bit regardless of the event bit.
- R8: Raw status reads at 0x414, masked status at 0x418 equals raw AND the enable byte (0x410), and `irq_out` is 1 exactly when masked status is non-zero.
- R9: Writing 0x41C clears the latched edge of each pin whose data bit is 1; 0 bits do nothing, level-sensed raw bits are not affected, and 0x41C reads 0.
- R10: An edge detected in the same cycle as a clear of that pin leaves the pin latched.
- R11: Writes to 0x414 and 0x418 change no state.
- R12: The mode byte at 0x420 reads back what was written and drives `pad_mode`.
- R13: An access with `bus_addr[1:0]` not 0, or to an unmapped register address, changes no state and reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 11 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 8 | Asynchronous pad inputs |
| pin_out | output | 8 | Output latch value |
| pin_oe | output | 8 | Per-pin output enable |
| pad_mode | output | 8 | Stored per-pin mode byte |
| irq_out | output | 1 | Combined interrupt |

## Verification
The pair that can coincide is an edge being latched by the detector and a clear write naming the same pin. The bench changes the pins, counts the two synchroniser edges so that the clear write is captured on the very edge where the detector sees the transition, and requires the raw bit to read 1 afterwards; a second run with the clear one cycle later must read 0. Around that, sweeps over every sensing configuration and a spread of pin transitions compare raw, masked and combined status with values worked out from the before and after pin bytes.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;

    localparam int PIN_W  = 8;
    localparam int SYNC_N = 2;

    // word index inside the configuration window (bus_addr[5:2])
    typedef enum logic [3:0] {
        IDX_DIR   = 4'd0,
        IDX_SENSE = 4'd1,
        IDX_BOTH  = 4'd2,
        IDX_EVT   = 4'd3,
        IDX_EN    = 4'd4,
        IDX_RAW   = 4'd5,
        IDX_MSK   = 4'd6,
        IDX_CLR   = 4'd7,
        IDX_MODE  = 4'd8
    } cfg_idx_e;

endpackage

// File: rtl/gpio8_sync.sv
module gpio8_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] smp,
    output logic [W-1:0] prev
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [W-1:0]             prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = st_q.chain[LAST];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign smp  = st_q.chain[LAST];
    assign prev = st_q.prev;

endmodule

// File: rtl/gpio8_irq_det.sv
module gpio8_irq_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] sense,
    input  logic [W-1:0] both,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    output logic [W-1:0] hit,
    output logic [W-1:0] lat,
    output logic [W-1:0] raw
);
    typedef struct packed {
        logic [W-1:0] lat;
    } det_t;

    det_t st_d, st_q;
    logic [W-1:0] lvl;

    for (genvar g = 0; g < W; g++) begin : g_pin
        logic rise, fall;
        assign rise   = smp[g] & ~prev[g];
        assign fall   = ~smp[g] & prev[g];
        assign hit[g] = ~sense[g] & (both[g] ? (rise | fall)
                                             : (evt[g] ? rise : fall));
        assign lvl[g] = evt[g] ? smp[g] : ~smp[g];
        assign raw[g] = sense[g] ? lvl[g] : st_q.lat[g];
    end

    always_comb begin
        st_d = st_q;
        // a new edge takes precedence over a clear of the same pin
        st_d.lat = (st_q.lat & ~clr) | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lat = st_q.lat;

endmodule

// File: rtl/gpio8_regs.sv
module gpio8_regs
    import gpio8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W+2:0]    bus_addr,
    input  logic            bus_we,
    input  logic [W-1:0]    bus_wdata,
    output logic [W-1:0]    bus_rdata,
    input  logic [W-1:0]    smp,
    input  logic [W-1:0]    raw,
    input  logic [W-1:0]    masked,
    output logic [W-1:0]    dir,
    output logic [W-1:0]    dout,
    output logic [W-1:0]    sense,
    output logic [W-1:0]    both,
    output logic [W-1:0]    evt,
    output logic [W-1:0]    en,
    output logic [W-1:0]    mode,
    output logic [W-1:0]    clr
);
    localparam int AW  = W + 3;
    localparam int TOP = AW - 1;

    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] dout;
        logic [W-1:0] sense;
        logic [W-1:0] both;
        logic [W-1:0] evt;
        logic [W-1:0] en;
        logic [W-1:0] mode;
    } regs_t;

    regs_t     st_d, st_q;
    logic      aligned, data_sel, cfg_sel;
    logic [W-1:0] mask;
    cfg_idx_e  idx;

    always_comb begin
        st_d      = st_q;
        clr       = '0;
        bus_rdata = '0;
        aligned   = (bus_addr[1:0] == 2'b00);
        mask      = bus_addr[TOP-1:2];
        idx       = cfg_idx_e'(bus_addr[5:2]);
        data_sel  = aligned && !bus_addr[TOP];
        cfg_sel   = aligned && bus_addr[TOP] && (bus_addr[TOP-1:6] == '0);

        if (bus_we && data_sel) begin
            st_d.dout = (st_q.dout & ~mask) | (bus_wdata & mask);
        end
        if (bus_we && cfg_sel) begin
            case (idx)
                IDX_DIR:   st_d.dir   = bus_wdata;
                IDX_SENSE: st_d.sense = bus_wdata;
                IDX_BOTH:  st_d.both  = bus_wdata;
                IDX_EVT:   st_d.evt   = bus_wdata;
                IDX_EN:    st_d.en    = bus_wdata;
                IDX_CLR:   clr        = bus_wdata;
                IDX_MODE:  st_d.mode  = bus_wdata;
                default:   ;
            endcase
        end

        if (data_sel) begin
            bus_rdata = ((st_q.dir & st_q.dout) | (~st_q.dir & smp)) & mask;
        end else if (cfg_sel) begin
            case (idx)
                IDX_DIR:   bus_rdata = st_q.dir;
                IDX_SENSE: bus_rdata = st_q.sense;
                IDX_BOTH:  bus_rdata = st_q.both;
                IDX_EVT:   bus_rdata = st_q.evt;
                IDX_EN:    bus_rdata = st_q.en;
                IDX_RAW:   bus_rdata = raw;
                IDX_MSK:   bus_rdata = masked;
                IDX_MODE:  bus_rdata = st_q.mode;
                default:   bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir   = st_q.dir;
    assign dout  = st_q.dout;
    assign sense = st_q.sense;
    assign both  = st_q.both;
    assign evt   = st_q.evt;
    assign en    = st_q.en;
    assign mode  = st_q.mode;

endmodule

// File: rtl/gpio8_ctrl.sv
module gpio8_ctrl
    import gpio8_pkg::*;
#(
    parameter int N_PIN = PIN_W,
    parameter int SYNC  = SYNC_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PIN+2:0]  bus_addr,
    input  logic              bus_we,
    input  logic [N_PIN-1:0]  bus_wdata,
    output logic [N_PIN-1:0]  bus_rdata,
    input  logic [N_PIN-1:0]  pin_in,
    output logic [N_PIN-1:0]  pin_out,
    output logic [N_PIN-1:0]  pin_oe,
    output logic [N_PIN-1:0]  pad_mode,
    output logic              irq_out
);
    logic [N_PIN-1:0] smp, prev;
    logic [N_PIN-1:0] dir, dout, sense, both, evt, en, mode, clr;
    logic [N_PIN-1:0] edge_hit, edge_lat, raw, masked;

    gpio8_sync #(.W(N_PIN), .STAGES(SYNC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .smp  (smp),
        .prev (prev)
    );

    gpio8_regs #(.W(N_PIN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .smp      (smp),
        .raw      (raw),
        .masked   (masked),
        .dir      (dir),
        .dout     (dout),
        .sense    (sense),
        .both     (both),
        .evt      (evt),
        .en       (en),
        .mode     (mode),
        .clr      (clr)
    );

    gpio8_irq_det #(.W(N_PIN)) u_det (
        .clk  (clk),
        .rst_n(rst_n),
        .smp  (smp),
        .prev (prev),
        .sense(sense),
        .both (both),
        .evt  (evt),
        .clr  (clr),
        .hit  (edge_hit),
        .lat  (edge_lat),
        .raw  (raw)
    );

    assign masked   = raw & en;
    assign irq_out  = |masked;
    assign pin_out  = dout;
    assign pin_oe   = dir;
    assign pad_mode = mode;

endmodule

// File: rtl/gpio8_ctrl_chk.sv
module gpio8_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [10:0] bus_addr,
    input logic        bus_we,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  pin_out,
    input logic [7:0]  pin_oe,
    input logic [7:0]  pad_mode,
    input logic [7:0]  edge_hit,
    input logic [7:0]  edge_lat
);
    logic [7:0] clr_m;
    assign clr_m = (bus_we && bus_addr == 11'h41C) ? bus_wdata : 8'h00;

    // R4
    dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 11'h400) |=> (pin_oe == $past(bus_wdata)));

    // R12
    mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 11'h420) |=> (pad_mode == $past(bus_wdata)));

    // R2
    data_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_addr[10] && bus_addr[1:0] == 2'b00)
        |=> (((pin_out ^ $past(pin_out)) & ~$past(bus_addr[9:2])) == 8'h00));

    // R13
    unaligned_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[1:0] != 2'b00)
        |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pad_mode)));

    // R10
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != 8'h00) |=> ((edge_lat & $past(edge_hit)) == $past(edge_hit)));

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_lat & $past(edge_lat & ~clr_m)) == $past(edge_lat & ~clr_m)));

endmodule

bind gpio8_ctrl gpio8_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .pad_mode (pad_mode),
    .edge_hit (edge_hit),
    .edge_lat (edge_lat)
);

// File: tb/gpio8_ctrl_bench.sv
module gpio8_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe, pad_mode;
    logic        irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    gpio8_ctrl u_gpio8_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .pad_mode (pad_mode),
        .irq_out  (irq_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // called at a negedge; returns at the next negedge
    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] d);
        bus_we   = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [10:0] dat_addr(input logic [7:0] m);
        return {1'b0, m, 2'b00};
    endfunction

    initial begin
        int wd = 0;
        while (!done && wd < 190000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", wd);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, out_e, raw_e, en, st;
        logic [7:0] starts [3];
        starts[0] = 8'h00; starts[1] = 8'hFF; starts[2] = 8'h5A;

        tick(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 pin_out", pin_out, 8'h00);
        check("R1 pad_mode", pad_mode, 8'h00);
        check("R1 irq_out", {7'd0, irq_out}, 8'h00);
        for (int i = 0; i < 9; i++) begin
            rd(11'h400 + 11'(i * 4), r);
            check("R1 register", r, 8'h00);
        end
        rd(dat_addr(8'hFF), r);
        check("R1 data", r, 8'h00);

        // R4 direction sweep, R12 mode sweep
        for (int v = 0; v < 256; v++) begin
            wr(11'h400, 8'(v));
            check("R4 pin_oe", pin_oe, 8'(v));
            rd(11'h400, r);
            check("R4 readback", r, 8'(v));
            wr(11'h420, 8'(v ^ 8'h3C));
            check("R12 pad_mode", pad_mode, 8'(v ^ 8'h3C));
            rd(11'h420, r);
            check("R12 readback", r, 8'(v ^ 8'h3C));
        end

        // R2 masked writes over every mask
        wr(11'h400, 8'hFF);
        out_e = 8'h00;
        for (int m = 0; m < 256; m++) begin
            logic [7:0] d;
            d = 8'(m * 37 + 11);
            wr(dat_addr(8'(m)), d);
            out_e = (out_e & ~8'(m)) | (d & 8'(m));
            check("R2 pin_out", pin_out, out_e);
        end
        // R3 masked reads, all outputs
        for (int m = 0; m < 256; m++) begin
            rd(dat_addr(8'(m)), r);
            check("R3 read out", r, out_e & 8'(m));
        end
        // R3 mixed direction
        wr(11'h400, 8'hA5);
        pin_in = 8'h3C;
        @(negedge clk);
        rd(dat_addr(8'hFF), r);
        check("R3 one edge not yet", r, 8'hA5 & out_e);
        tick(1);
        for (int m = 0; m < 256; m++) begin
            rd(dat_addr(8'(m)), r);
            check("R3 read mixed", r, ((8'hA5 & out_e) | (8'h5A & 8'h3C)) & 8'(m));
        end
        for (int p = 0; p < 256; p += 5) begin
            pin_in = 8'(p);
            tick(2);
            rd(dat_addr(8'hFF), r);
            check("R3 read inputs", r, (8'hA5 & out_e) | (8'h5A & 8'(p)));
        end
        wr(11'h400, 8'h00);

        // R5..R9 sweep over every sensing configuration
        for (int cfg = 0; cfg < 8; cfg++) begin
            logic s, b, e;
            s = cfg[2]; b = cfg[1]; e = cfg[0];
            wr(11'h404, {8{s}});
            wr(11'h408, {8{b}});
            wr(11'h40C, {8{e}});
            for (int si = 0; si < 3; si++) begin
                st = starts[si];
                for (int nv = 0; nv < 256; nv += 3) begin
                    logic [7:0] rise, fall;
                    pin_in = st;
                    tick(4);
                    wr(11'h41C, 8'hFF);
                    en = 8'(nv) ^ 8'h96;
                    wr(11'h410, en);
                    pin_in = 8'(nv);
                    tick(4);
                    rise = ~st & 8'(nv);
                    fall = st & ~8'(nv);
                    if (s)      raw_e = e ? 8'(nv) : ~8'(nv);
                    else if (b) raw_e = rise | fall;
                    else        raw_e = e ? rise : fall;
                    rd(11'h414, r);
                    if (s)      check("R5 level raw", r, raw_e);
                    else if (b) check("R7 both edges raw", r, raw_e);
                    else        check("R6 single edge raw", r, raw_e);
                    rd(11'h418, r);
                    check("R8 masked", r, raw_e & en);
                    check("R8 irq_out", {7'd0, irq_out}, {7'd0, |(raw_e & en)});
                    wr(11'h41C, 8'h00);
                    rd(11'h414, r);
                    check("R9 zero clear", r, raw_e);
                    wr(11'h41C, 8'h0F);
                    rd(11'h414, r);
                    check("R9 partial clear", r, s ? raw_e : (raw_e & 8'hF0));
                end
            end
        end
        rd(11'h41C, r);
        check("R9 clear reads zero", r, 8'h00);

        // R10 edge and clear in the same cycle
        wr(11'h404, 8'h00);
        wr(11'h408, 8'hFF);
        wr(11'h410, 8'hFF);
        pin_in = 8'h00;
        tick(4);
        wr(11'h41C, 8'hFF);
        pin_in = 8'hFF;
        tick(2);
        wr(11'h41C, 8'hFF);   // captured on the edge the detector fires
        rd(11'h414, r);
        check("R10 edge wins", r, 8'hFF);
        // control: clear one cycle later removes it
        pin_in = 8'h00;
        tick(3);
        wr(11'h41C, 8'hFF);
        rd(11'h414, r);
        check("R10 later clear", r, 8'h00);
        pin_in = 8'hFF;
        tick(4);

        // R11 status registers are read-only
        wr(11'h414, 8'h00);
        wr(11'h418, 8'h00);
        rd(11'h414, r);
        check("R11 raw kept", r, 8'hFF);
        rd(11'h418, r);
        check("R11 masked kept", r, 8'hFF);
        check("R11 irq kept", {7'd0, irq_out}, 8'h01);

        // R13 unaligned and unmapped accesses
        wr(11'h400, 8'h5A);
        wr(11'h401, 8'hFF);
        check("R13 unaligned dir", pin_oe, 8'h5A);
        rd(11'h401, r);
        check("R13 unaligned read", r, 8'h00);
        wr(dat_addr(8'hFF) | 11'h002, 8'h00);
        check("R13 unaligned data", pin_out, out_e);
        wr(11'h424, 8'hFF);
        rd(11'h424, r);
        check("R13 unmapped read", r, 8'h00);
        check("R13 unmapped mode", pad_mode, 8'(255 ^ 8'h3C));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule